// File: doc/BRIEF.md
# Watchdog / Interval Timer with Dual Prescaler

This block is an 8-bit up-counting timer that serves either as a periodic interval timer or as a watchdog. Its count ticks come from one of two prescaler chains. The fast chain divides a main-clock tick input, and the slow chain divides a sub-clock tick input. The ratio is chosen by a 3-bit divider select. When the counter wraps from 0xFF to 0x00, it sets an overflow flag. In interval mode the flag drives a level interrupt request. In watchdog mode the wrap fires a one-cycle pulse instead: either a non-maskable interrupt request or an internal reset request.

Software reaches the block through one control byte and a count readout. A write is accepted only when the upper byte of the 16-bit write word carries the key 0xA5. The overflow flag can only be cleared. Clearing it takes a write of 0 that follows a read which returned the flag as 1. Writing the enable bit to 0 also clears the flag.

Top module: `wdt_timer`

## Requirements
- R1: After synchronous reset, the control byte and the count both read 0x00, and irq_ivl, rst_req and nmi_req are all low.
- R2: A write with wr_en high is accepted only when wr_word[15:8] equals 0xA5. The accepted write loads control bits 6:0 from wr_word[6:0]. Any other key leaves the control byte unchanged.
- R3: While the enable bit (control bit 0) is 0, the count is forced to 0x00 and holds. Writing the enable bit to 0 clears the overflow flag.
- R4: With the source bit (control bit 2) at 0, the count advances once per D main ticks. The divider select in bits 6:4 gives D as follows: 0→2, 1→64, 2→128, 3→512, 4→2048, 5→8192, 6→32768, 7→131072. The first increment comes on the D-th tick after enabling.
- R5: With the source bit at 1, the count advances once per D sub ticks, where D = 2^(select+1), so the range is 2 to 256.
- R6: The count wraps from 0xFF to 0x00. The wrap sets the overflow flag (control bit 7), except in watchdog reset mode.
- R7: A write of 0 to the flag clears it only if an earlier read of the control byte (rd_en high, rd_sel 0) saw the flag at 1. A write of 0 without that read leaves the flag set. A write of 1 never sets it.
- R8: irq_ivl is high exactly while the flag is set and the mode bit (control bit 1) is 0, meaning interval mode.
- R9: In watchdog mode (mode bit 1) with the action bit (control bit 3) at 0, a wrap sets the flag and raises nmi_req for exactly one cycle.
- R10: In watchdog mode with the action bit at 1, a wrap raises rst_req for exactly one cycle, and the flag stays clear.
- R11: rd_data shows the control byte when rd_sel is 0 and the count when rd_sel is 1, without delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| main_tick | input | 1 | Main-clock enable tick |
| sub_tick | input | 1 | Sub-clock enable tick |
| wr_en | input | 1 | Control write strobe |
| wr_word | input | 16 | Key in [15:8], control byte in [7:0] |
| rd_en | input | 1 | Read strobe (arms the flag clear) |
| rd_sel | input | 1 | 0 = control byte, 1 = count |
| rd_data | output | 8 | Read data |
| irq_ivl | output | 1 | Interval interrupt request (level) |
| rst_req | output | 1 | Watchdog reset request pulse |
| nmi_req | output | 1 | Watchdog NMI request pulse |

## Verification
An accepted write is visible on rd_data right after the clock edge that samples it. Counting starts from that edge, so with divider D the count equals floor((n-1)/D) after n edges, and the wrap is due at n = 256·D + 1. At that same edge the flag, irq_ivl and the watchdog pulse all appear, and the pulse is gone one edge later. The driver counts edges from each write, and it queues each expected value tagged with the exact cycle it falls due. The monitor compares it at the falling edge of that cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int          CNT_W  = 8;
    localparam int          MAIN_W = 17;
    localparam int          SUB_W  = 8;
    localparam logic [7:0]  WR_KEY = 8'hA5;

    // control byte, MSB first: flag, divider select, action, source, mode, enable
    typedef struct packed {
        logic       ovf;
        logic [2:0] div;
        logic       act;
        logic       src;
        logic       mode;
        logic       en;
    } ctrl_t;

    // log2 of the division ratio for a chain and a select value
    function automatic int div_exp(input logic sub, input logic [2:0] sel);
        if (sub) return int'(sel) + 1;
        case (sel)
            3'd0:    return 1;
            3'd1:    return 6;
            3'd2:    return 7;
            3'd3:    return 9;
            3'd4:    return 11;
            3'd5:    return 13;
            3'd6:    return 15;
            default: return 17;
        endcase
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int   W   = MAIN_W,
    parameter logic SUB = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick_in,
    input  logic [2:0] sel,
    output logic       tick_out
);
    logic [W-1:0] cnt;
    logic [W:0]   span;
    logic [W-1:0] mask;

    always_comb begin
        span = ({{W{1'b0}}, 1'b1} << div_exp(SUB, sel)) - 1'b1;
        mask = span[W-1:0];
    end

    assign tick_out = en & tick_in & (&(cnt | ~mask));

    always_ff @(posedge clk) begin
        if (rst || !en) cnt <= '0;
        else if (tick_in) cnt <= cnt + 1'b1;
    end

    // R3
    psc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> (cnt == '0));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    assign wrap = en & tick & (&count);

    always_ff @(posedge clk) begin
        if (rst || !en) count <= '0;
        else if (tick) count <= count + 1'b1;
    end

    // R3
    cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> (count == '0));
    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && tick && !(&count)) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_word,
    input  logic        rd_en,
    input  logic        rd_sel,
    input  logic        wrap,
    output ctrl_t       ctrl
);
    logic  armed, arm_n;
    logic  wr_ok;
    ctrl_t nxt;

    assign wr_ok = wr_en && (wr_word[15:8] == WR_KEY);

    always_comb begin
        nxt   = ctrl;
        arm_n = armed;
        if (rd_en && !rd_sel && ctrl.ovf) arm_n = 1'b1;
        if (wr_ok) begin
            nxt     = ctrl_t'(wr_word[7:0]);
            nxt.ovf = ctrl.ovf;
            if (!wr_word[0])              nxt.ovf = 1'b0;
            else if (armed && !wr_word[7]) nxt.ovf = 1'b0;
            arm_n = 1'b0;
        end
        if (wrap) nxt.ovf = !(ctrl.mode && ctrl.act);
        if (!nxt.ovf) arm_n = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            armed <= 1'b0;
        end else begin
            ctrl  <= nxt;
            armed <= arm_n;
        end
    end

    // R2
    key_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_word[15:8] != WR_KEY) |=>
        ($stable(ctrl.div) && $stable(ctrl.act) && $stable(ctrl.src)
         && $stable(ctrl.mode) && $stable(ctrl.en)));
    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap && !(ctrl.mode && ctrl.act)) |=> ctrl.ovf);
    // R7
    flag_noset_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.ovf && !wrap) |=> !ctrl.ovf);
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        main_tick,
    input  logic        sub_tick,
    input  logic        wr_en,
    input  logic [15:0] wr_word,
    input  logic        rd_en,
    input  logic        rd_sel,
    output logic [7:0]  rd_data,
    output logic        irq_ivl,
    output logic        rst_req,
    output logic        nmi_req
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] count;
    logic             wrap;
    logic [1:0]       src_tick;
    logic [1:0]       div_tick;

    assign src_tick = {sub_tick, main_tick};

    wdt_ctrl u_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word),
        .rd_en(rd_en), .rd_sel(rd_sel), .wrap(wrap), .ctrl(ctrl)
    );

    for (genvar g = 0; g < 2; g++) begin : g_chain
        wdt_prescaler #(
            .W  (g == 1 ? SUB_W : MAIN_W),
            .SUB(g == 1 ? 1'b1 : 1'b0)
        ) u_psc (
            .clk(clk), .rst(rst), .en(ctrl.en),
            .tick_in(src_tick[g]), .sel(ctrl.div), .tick_out(div_tick[g])
        );
    end

    wdt_counter u_cnt (
        .clk(clk), .rst(rst), .en(ctrl.en),
        .tick(div_tick[ctrl.src]), .count(count), .wrap(wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req <= 1'b0;
            nmi_req <= 1'b0;
        end else begin
            rst_req <= wrap & ctrl.mode & ctrl.act;
            nmi_req <= wrap & ctrl.mode & ~ctrl.act;
        end
    end

    assign irq_ivl = ctrl.ovf & ~ctrl.mode;
    assign rd_data = rd_sel ? count : ctrl;

    // R9
    nmi_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_req |=> !nmi_req);
    // R10
    rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);
    // R10
    req_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rst_req && nmi_req));
    // R8
    irq_mode_chk: assert property (@(posedge clk) disable iff (rst)
        irq_ivl |-> !ctrl.mode);
endmodule

// File: tb/wdt_timer_test.sv
module wdt_timer_test;
    localparam int CLK_PERIOD = 10;

    localparam int SIG_RD  = 0;
    localparam int SIG_IRQ = 1;
    localparam int SIG_RST = 2;
    localparam int SIG_NMI = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        main_tick = 1'b1;
    logic        sub_tick = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_word = '0;
    logic        rd_en = 1'b0;
    logic        rd_sel = 1'b0;
    logic [7:0]  rd_data;
    logic        irq_ivl, rst_req, nmi_req;

    typedef struct {
        int         due;
        int         sig;
        logic [7:0] val;
        string      req;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n = 0;
    int    tests = 0;
    int    fails = 0;
    bit    done = 1'b0;

    wdt_timer uut (
        .clk(clk), .rst(rst), .main_tick(main_tick), .sub_tick(sub_tick),
        .wr_en(wr_en), .wr_word(wr_word), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq_ivl(irq_ivl), .rst_req(rst_req), .nmi_req(nmi_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops every item due in this cycle
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].due <= cyc) begin
                item_t it;
                logic [7:0] act;
                it = q.pop_front();
                case (it.sig)
                    SIG_RD:  act = rd_data;
                    SIG_IRQ: act = {7'd0, irq_ivl};
                    SIG_RST: act = {7'd0, rst_req};
                    default: act = {7'd0, nmi_req};
                endcase
                tests++;
                if (act !== it.val) begin
                    fails++;
                    $display("FAIL %s sig%0d: actual %h expected %h (cycle %0d)",
                             it.req, it.sig, act, it.val, cyc);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        n++;
    endtask

    task automatic expect_sig(input int sig, input logic [7:0] val, input string req);
        item_t it;
        it.due = cyc; it.sig = sig; it.val = val; it.req = req;
        q.push_back(it);
    endtask

    task automatic expect_rd(input logic sel, input logic [7:0] val, input string req);
        rd_sel = sel;
        expect_sig(SIG_RD, val, req);
    endtask

    // drives one write; the edge that takes it is edge n = 1
    task automatic write(input logic [7:0] key, input logic [7:0] data);
        wr_en = 1'b1;
        wr_word = {key, data};
        n = 0;
        step();
        wr_en = 1'b0;
    endtask

    task automatic go_to(input int target);
        while (n < target) step();
    endtask

    task automatic restart(input logic [7:0] data);
        write(8'hA5, 8'h00);
        go_to(3);
        write(8'hA5, data);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        expect_rd(1'b0, 8'h00, "R1");
        step();
        expect_rd(1'b1, 8'h00, "R1");
        expect_sig(SIG_IRQ, 8'h00, "R1");
        expect_sig(SIG_RST, 8'h00, "R1");
        expect_sig(SIG_NMI, 8'h00, "R1");

        // R2 wrong key ignored
        write(8'h5A, 8'h05);
        go_to(5);
        expect_rd(1'b0, 8'h00, "R2");
        step();
        expect_rd(1'b1, 8'h00, "R2");

        // interval mode, sub chain /2: R2 R11 R5 R6 R8
        write(8'hA5, 8'h05);
        expect_rd(1'b0, 8'h05, "R2");
        go_to(3);
        expect_rd(1'b1, 8'h01, "R11");
        go_to(512);
        expect_rd(1'b1, 8'hFF, "R6");
        expect_sig(SIG_IRQ, 8'h00, "R8");
        step();
        expect_rd(1'b0, 8'h85, "R6");
        expect_sig(SIG_IRQ, 8'h01, "R8");
        step();
        expect_rd(1'b1, 8'h00, "R6");

        // R7 clear rule
        write(8'hA5, 8'h05);
        step();
        expect_rd(1'b0, 8'h85, "R7");
        write(8'hA5, 8'h85);
        step();
        expect_rd(1'b0, 8'h85, "R7");
        rd_sel = 1'b0;
        rd_en = 1'b1;
        step();
        rd_en = 1'b0;
        write(8'hA5, 8'h05);
        expect_rd(1'b0, 8'h05, "R7");
        expect_sig(SIG_IRQ, 8'h00, "R8");
        write(8'hA5, 8'h85);
        step();
        expect_rd(1'b0, 8'h05, "R7");

        // main chain /2 then disable: R4 R3
        restart(8'h01);
        go_to(3);
        expect_rd(1'b1, 8'h01, "R4");
        go_to(513);
        expect_rd(1'b0, 8'h81, "R6");
        write(8'hA5, 8'h00);
        expect_rd(1'b0, 8'h00, "R3");
        go_to(3);
        expect_rd(1'b1, 8'h00, "R3");
        go_to(13);
        expect_rd(1'b1, 8'h00, "R3");

        // main chain /64: R4
        restart(8'h11);
        go_to(64);
        expect_rd(1'b1, 8'h00, "R4");
        step();
        expect_rd(1'b1, 8'h01, "R4");
        go_to(129);
        expect_rd(1'b1, 8'h02, "R4");

        // sub chain /16 and /256: R5
        restart(8'h35);
        go_to(16);
        expect_rd(1'b1, 8'h00, "R5");
        step();
        expect_rd(1'b1, 8'h01, "R5");
        restart(8'h75);
        go_to(256);
        expect_rd(1'b1, 8'h00, "R5");
        step();
        expect_rd(1'b1, 8'h01, "R5");

        // watchdog NMI: R9
        restart(8'h07);
        go_to(512);
        expect_sig(SIG_NMI, 8'h00, "R9");
        step();
        expect_sig(SIG_NMI, 8'h01, "R9");
        expect_sig(SIG_RST, 8'h00, "R9");
        expect_sig(SIG_IRQ, 8'h00, "R8");
        expect_rd(1'b0, 8'h87, "R9");
        step();
        expect_sig(SIG_NMI, 8'h00, "R9");

        // watchdog reset: R10
        restart(8'h0F);
        go_to(512);
        expect_sig(SIG_RST, 8'h00, "R10");
        step();
        expect_sig(SIG_RST, 8'h01, "R10");
        expect_sig(SIG_NMI, 8'h00, "R10");
        expect_rd(1'b0, 8'h0F, "R10");
        step();
        expect_sig(SIG_RST, 8'h00, "R10");
        expect_rd(1'b0, 8'h0F, "R10");

        repeat (3) step();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule